// File: doc/BRIEF.md
# SD Host Single-Segment DMA Engine

This block is the DMA engine that sits inside an SD host controller and moves one contiguous run of data between the controller's data stream and system memory. Software programs a transfer mode, a 64-bit start address and a byte count, then sets a go bit. The engine issues one memory request per beat, either reading memory and handing words to the card-side transmit stream, or taking words from the card-side receive stream and writing them to memory. It raises a one-cycle completion pulse when the final beat has finished.

Two channels share the engine. Channel 0 carries memory-to-device traffic and channel 1 carries device-to-memory traffic. Each channel has its own hold bit: clearing it aborts that channel's transfer in progress and wipes its error flag. A memory error response ends a transfer early and leaves a sticky error flag for the channel.

Register access is a simple word-indexed write strobe with combinational read-back. The memory side is a request/acknowledge port, and the card side is a pair of valid/ready streams.

Top module: `sd_dma_unit`

## Requirements
- R1: The register index map is MODE=0, CTRL=1, CHRST=2, ADDR_LO=3, ADDR_HI=4, STATUS=5. After reset, MODE, CTRL, STATUS and both address words read 0, CHRST reads 0x300 (bit 8 is channel 0, bit 9 is channel 1, and both are released), and no memory request or stream handshake is offered.
- R2: Writing CTRL with bit 0 set while idle starts a transfer if the channel for the programmed direction is released. CTRL bit 0 reads 1 while a transfer runs and returns to 0 by itself when it ends.
- R3: When MODE[17:16] is any value other than 1, the transfer runs memory-to-device on channel 0. Each beat is a memory read (mem_wr=0), and the returned word is presented on the transmit stream, in address order.
- R4: When MODE[17:16]=1, the transfer runs device-to-memory on channel 1. Each word accepted from the receive stream is written to memory (mem_wr=1) with that word as data, in order.
- R5: MODE[5:4] selects the beat size of 1, 2, 4 or 8 bytes for codes 0 to 3. mem_size carries the same code, and the beat count is the latched byte count divided by the beat size, with any remainder dropped.
- R6: When MODE[0]=1, the memory address advances by the beat size after every beat. When MODE[0]=0, every beat uses the start address.
- R7: The first beat's address is {ADDR_HI, ADDR_LO}, so all 64 bits reach mem_addr.
- R8: xfer_done pulses for exactly one cycle, on the cycle after the final beat's handshake. A start whose beat count is zero produces the pulse on the cycle after the start write and issues no memory request.
- R9: Writes to MODE, ADDR_LO or ADDR_HI while a transfer is running are ignored. The running transfer and the later read-back both keep the original values.
- R10: Clearing the active channel's CHRST bit stops its transfer by the second clock edge after the write. No completion pulse is given, and starts on a held channel are refused.
- R11: An error on a memory acknowledge ends the transfer without a completion pulse and sets STATUS bit 0 (channel 0) or bit 1 (channel 1). The bit stays set across later transfers until that channel is held in reset.
- R12: A start in 8-byte mode with a start address not aligned to 8 bytes is refused. No memory request is made and the channel's STATUS error bit is set.
- R13: mem_req, once raised, is held with a stable address and direction until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx |
| xfer_bytes | input | 16 | Byte count, latched at start |
| mem_req | output | 1 | Memory request |
| mem_wr | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 64 | Memory byte address |
| mem_size | output | 2 | Beat size code |
| mem_wdata | output | 64 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, completes the request |
| mem_err | input | 1 | Error response, valid with mem_ack |
| mem_rdata | input | 64 | Memory read data, valid with mem_ack |
| fifo_tx_valid | output | 1 | Transmit stream word valid |
| fifo_tx_data | output | 64 | Transmit stream word |
| fifo_tx_ready | input | 1 | Transmit stream ready |
| fifo_rx_valid | input | 1 | Receive stream word valid |
| fifo_rx_data | input | 64 | Receive stream word |
| fifo_rx_ready | output | 1 | Receive stream ready |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
Register writes take effect at the clock edge that ends the write cycle. Read-back is combinational, so a status change made by the engine at the following edge is visible one cycle later. The completion pulse follows the last handshake by one edge, and a channel hold stops the engine one edge after the hold bit has been written. The bench drives every input and samples every output on the falling clock edge. Each expectation is taken in the cycle these counts give. Memory and stream handshakes are compared against a queue of expected beats at the falling edge before the rising edge that completes them.

// File: rtl/sd_dma_pkg.sv
package sd_dma_pkg;

    localparam int REG_W = 32;
    localparam int IDX_W = 3;
    localparam int NCH   = 2;

    // register word indices
    localparam logic [IDX_W-1:0] REG_MODE    = 3'd0;
    localparam logic [IDX_W-1:0] REG_CTRL    = 3'd1;
    localparam logic [IDX_W-1:0] REG_CHRST   = 3'd2;
    localparam logic [IDX_W-1:0] REG_ADDR_LO = 3'd3;
    localparam logic [IDX_W-1:0] REG_ADDR_HI = 3'd4;
    localparam logic [IDX_W-1:0] REG_STATUS  = 3'd5;

    // field positions that software depends on
    localparam int MODE_DIR_LSB = 16;
    localparam int MODE_WID_LSB = 4;
    localparam int MODE_INC_BIT = 0;
    localparam int CTRL_GO_BIT  = 0;
    localparam int CHRST_LSB    = 8;

    localparam logic [1:0] DIR_DEV_TO_MEM = 2'd1;
    localparam logic [1:0] SIZE_64        = 2'd3;

    typedef struct packed {
        logic [1:0] dir;
        logic [1:0] width;
        logic       inc;
    } mode_t;

    typedef enum logic [2:0] {
        ENG_IDLE = 3'd0,
        ENG_RD   = 3'd1,
        ENG_PUSH = 3'd2,
        ENG_PULL = 3'd3,
        ENG_WR   = 3'd4
    } eng_st_e;

endpackage

// File: rtl/sd_dma_regs.sv
module sd_dma_regs
    import sd_dma_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [REG_W-1:0] wdata,
    input  logic             busy,
    input  logic [NCH-1:0]   err,
    output logic [REG_W-1:0] rdata,
    output mode_t            mode,
    output logic [AW-1:0]    base,
    output logic [NCH-1:0]   run,
    output logic             go
);
    localparam int HI_W = AW - REG_W;

    typedef struct packed {
        mode_t          mode;
        logic [AW-1:0]  base;
        logic [NCH-1:0] run;
    } regs_t;

    regs_t d, q;

    always_comb begin
        d = q;
        if (we) begin
            case (idx)
                REG_MODE: if (!busy) begin
                    d.mode.dir   = wdata[MODE_DIR_LSB +: 2];
                    d.mode.width = wdata[MODE_WID_LSB +: 2];
                    d.mode.inc   = wdata[MODE_INC_BIT];
                end
                REG_ADDR_LO: if (!busy) d.base[REG_W-1:0] = wdata;
                REG_ADDR_HI: if (!busy) d.base[AW-1:REG_W] = wdata[HI_W-1:0];
                REG_CHRST:   d.run = wdata[CHRST_LSB +: NCH];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode <= '0;
            q.base <= '0;
            q.run  <= '1;
        end else begin
            q <= d;
        end
    end

    assign go   = we && (idx == REG_CTRL) && wdata[CTRL_GO_BIT];
    assign mode = q.mode;
    assign base = q.base;
    assign run  = q.run;

    always_comb begin
        rdata = '0;
        case (idx)
            REG_MODE: begin
                rdata[MODE_DIR_LSB +: 2] = q.mode.dir;
                rdata[MODE_WID_LSB +: 2] = q.mode.width;
                rdata[MODE_INC_BIT]      = q.mode.inc;
            end
            REG_CTRL:    rdata[CTRL_GO_BIT] = busy;
            REG_CHRST:   rdata[CHRST_LSB +: NCH] = q.run;
            REG_ADDR_LO: rdata = q.base[REG_W-1:0];
            REG_ADDR_HI: rdata[HI_W-1:0] = q.base[AW-1:REG_W];
            REG_STATUS:  rdata[NCH-1:0] = err;
            default: ;
        endcase
    end

endmodule

// File: rtl/sd_dma_stride.sv
module sd_dma_stride #(
    parameter int AW = 64
) (
    input  logic [AW-1:0] cur,
    input  logic [1:0]    width,
    input  logic          inc,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] step;

    assign step = AW'(1) << width;
    assign nxt  = inc ? (cur + step) : cur;

endmodule

// File: rtl/sd_dma_engine.sv
module sd_dma_engine
    import sd_dma_pkg::*;
#(
    parameter int AW = 64,
    parameter int DW = 64,
    parameter int LW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  mode_t          mode,
    input  logic [AW-1:0]  base,
    input  logic [LW-1:0]  xfer_bytes,
    input  logic [NCH-1:0] run,
    input  logic           mem_ack,
    input  logic           mem_err,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           fifo_tx_ready,
    input  logic           fifo_rx_valid,
    input  logic [DW-1:0]  fifo_rx_data,
    output logic           busy,
    output logic           done,
    output logic [NCH-1:0] err,
    output logic           mem_req,
    output logic           mem_wr,
    output logic [AW-1:0]  mem_addr,
    output logic [1:0]     mem_size,
    output logic [DW-1:0]  mem_wdata,
    output logic           fifo_tx_valid,
    output logic [DW-1:0]  fifo_tx_data,
    output logic           fifo_rx_ready
);
    typedef struct packed {
        eng_st_e        st;
        logic [AW-1:0]  addr;
        logic [LW-1:0]  left;
        logic           ch;
        logic [1:0]     size;
        logic           inc;
        logic [DW-1:0]  word;
        logic           done;
        logic [NCH-1:0] err;
    } eng_t;

    eng_t d, q;

    logic [AW-1:0] step_addr;
    logic [LW-1:0] beats;
    logic          want_rx;
    logic          misaligned;
    logic          last_beat;

    sd_dma_stride #(.AW(AW)) u_stride (
        .cur   (q.addr),
        .width (q.size),
        .inc   (q.inc),
        .nxt   (step_addr)
    );

    assign beats      = xfer_bytes >> mode.width;
    assign want_rx    = (mode.dir == DIR_DEV_TO_MEM);
    assign misaligned = (mode.width == SIZE_64) && (base[2:0] != 3'd0);
    assign last_beat  = (q.left == LW'(1));

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ENG_IDLE: begin
                if (go && run[want_rx]) begin
                    if (misaligned) begin
                        d.err[want_rx] = 1'b1;
                    end else if (beats == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.st   = want_rx ? ENG_PULL : ENG_RD;
                        d.addr = base;
                        d.left = beats;
                        d.ch   = want_rx;
                        d.size = mode.width;
                        d.inc  = mode.inc;
                    end
                end
            end
            ENG_RD: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        d.err[q.ch] = 1'b1;
                        d.st        = ENG_IDLE;
                    end else begin
                        d.word = mem_rdata;
                        d.st   = ENG_PUSH;
                    end
                end
            end
            ENG_PUSH: begin
                if (fifo_tx_ready) begin
                    d.left = q.left - 1'b1;
                    d.addr = step_addr;
                    if (last_beat) begin
                        d.st   = ENG_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.st = ENG_RD;
                    end
                end
            end
            ENG_PULL: begin
                if (fifo_rx_valid) begin
                    d.word = fifo_rx_data;
                    d.st   = ENG_WR;
                end
            end
            ENG_WR: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        d.err[q.ch] = 1'b1;
                        d.st        = ENG_IDLE;
                    end else begin
                        d.left = q.left - 1'b1;
                        d.addr = step_addr;
                        if (last_beat) begin
                            d.st   = ENG_IDLE;
                            d.done = 1'b1;
                        end else begin
                            d.st = ENG_PULL;
                        end
                    end
                end
            end
            default: d.st = ENG_IDLE;
        endcase

        // a held channel abandons its transfer silently
        if (q.st != ENG_IDLE && !run[q.ch]) begin
            d.st   = ENG_IDLE;
            d.done = 1'b0;
        end

        for (int c = 0; c < NCH; c++) begin
            if (!run[c]) d.err[c] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy          = (q.st != ENG_IDLE);
    assign done          = q.done;
    assign err           = q.err;
    assign mem_req       = (q.st == ENG_RD) || (q.st == ENG_WR);
    assign mem_wr        = (q.st == ENG_WR);
    assign mem_addr      = q.addr;
    assign mem_size      = q.size;
    assign mem_wdata     = q.word;
    assign fifo_tx_valid = (q.st == ENG_PUSH);
    assign fifo_tx_data  = q.word;
    assign fifo_rx_ready = (q.st == ENG_PULL);

endmodule

// File: rtl/sd_dma_unit.sv
module sd_dma_unit
    import sd_dma_pkg::*;
#(
    parameter int AW = 64,
    parameter int DW = 64,
    parameter int LW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [LW-1:0]    xfer_bytes,
    output logic             mem_req,
    output logic             mem_wr,
    output logic [AW-1:0]    mem_addr,
    output logic [1:0]       mem_size,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic             mem_err,
    input  logic [DW-1:0]    mem_rdata,
    output logic             fifo_tx_valid,
    output logic [DW-1:0]    fifo_tx_data,
    input  logic             fifo_tx_ready,
    input  logic             fifo_rx_valid,
    input  logic [DW-1:0]    fifo_rx_data,
    output logic             fifo_rx_ready,
    output logic             xfer_done
);
    logic           go;
    mode_t          mode;
    logic [AW-1:0]  base;
    logic [NCH-1:0] chan_run;
    logic           eng_busy;
    logic [NCH-1:0] eng_err;

    sd_dma_regs #(.AW(AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .idx   (reg_idx),
        .wdata (reg_wdata),
        .busy  (eng_busy),
        .err   (eng_err),
        .rdata (reg_rdata),
        .mode  (mode),
        .base  (base),
        .run   (chan_run),
        .go    (go)
    );

    sd_dma_engine #(.AW(AW), .DW(DW), .LW(LW)) u_eng (
        .clk           (clk),
        .rst_n         (rst_n),
        .go            (go),
        .mode          (mode),
        .base          (base),
        .xfer_bytes    (xfer_bytes),
        .run           (chan_run),
        .mem_ack       (mem_ack),
        .mem_err       (mem_err),
        .mem_rdata     (mem_rdata),
        .fifo_tx_ready (fifo_tx_ready),
        .fifo_rx_valid (fifo_rx_valid),
        .fifo_rx_data  (fifo_rx_data),
        .busy          (eng_busy),
        .done          (xfer_done),
        .err           (eng_err),
        .mem_req       (mem_req),
        .mem_wr        (mem_wr),
        .mem_addr      (mem_addr),
        .mem_size      (mem_size),
        .mem_wdata     (mem_wdata),
        .fifo_tx_valid (fifo_tx_valid),
        .fifo_tx_data  (fifo_tx_data),
        .fifo_rx_ready (fifo_rx_ready)
    );

endmodule

// File: rtl/sd_dma_unit_chk.sv
module sd_dma_unit_chk #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic [1:0]    run,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic [1:0]    mem_size,
    input logic          fifo_tx_valid,
    input logic          fifo_rx_ready,
    input logic          xfer_done
);
    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && run == 2'b11) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_wr)));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !fifo_tx_valid && !fifo_rx_ready));

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !busy);

    assert_aligned_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_size == 2'd3) |-> (mem_addr[2:0] == 3'd0));

    assert_one_side_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_tx_valid && fifo_rx_ready));

    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run == 2'b00) |=> !busy);

endmodule

bind sd_dma_unit sd_dma_unit_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (eng_busy),
    .run           (chan_run),
    .mem_req       (mem_req),
    .mem_ack       (mem_ack),
    .mem_wr        (mem_wr),
    .mem_addr      (mem_addr),
    .mem_size      (mem_size),
    .fifo_tx_valid (fifo_tx_valid),
    .fifo_rx_ready (fifo_rx_ready),
    .xfer_done     (xfer_done)
);

// File: tb/sd_dma_unit_test.sv
module sd_dma_unit_test;
    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] I_MODE = 3'd0, I_CTRL = 3'd1, I_CHRST = 3'd2,
                           I_ALO = 3'd3, I_AHI = 3'd4, I_STAT = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] xfer_bytes = '0;
    logic        mem_req, mem_wr;
    logic [63:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic        mem_ack = 1'b0, mem_err = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        fifo_tx_valid;
    logic [63:0] fifo_tx_data;
    logic        fifo_tx_ready = 1'b0;
    logic        fifo_rx_valid = 1'b0;
    logic [63:0] fifo_rx_data = '0;
    logic        fifo_rx_ready;
    logic        xfer_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    sd_dma_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_bytes(xfer_bytes),
        .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_err(mem_err), .mem_rdata(mem_rdata), .fifo_tx_valid(fifo_tx_valid),
        .fifo_tx_data(fifo_tx_data), .fifo_tx_ready(fifo_tx_ready),
        .fifo_rx_valid(fifo_rx_valid), .fifo_rx_data(fifo_rx_data),
        .fifo_rx_ready(fifo_rx_ready), .xfer_done(xfer_done)
    );

    typedef struct packed {
        logic [63:0] a;
        logic [63:0] d;
        logic        wr;
        logic [1:0]  sz;
    } mitem_t;

    mitem_t      mq[$];
    logic [63:0] tq[$];

    int n_chk = 0, n_fail = 0;
    int cyc = 0, rx_idx = 0, done_cnt = 0;
    bit rx_hs = 0, err_arm = 0, finished = 0;

    function automatic logic [63:0] pat(input logic [63:0] a);
        return {a[31:0] ^ 32'h5A5A_0F0F, a[31:0] + 32'h1357_9BDF};
    endfunction

    function automatic logic [63:0] rxval(input int i);
        return {32'hC0DE_0000 | 32'(i), 32'h0000_1000 + 32'(i)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory, stream models and scoreboard monitor, all on the falling edge
    always @(negedge clk) begin
        cyc++;
        if (xfer_done) done_cnt++;
        if (rx_hs) rx_idx++;
        fifo_rx_valid = 1'b1;
        fifo_rx_data  = rxval(rx_idx);
        rx_hs = fifo_rx_ready;

        fifo_tx_ready = (cyc % 3) != 1;
        if (fifo_tx_valid && fifo_tx_ready) begin
            if (tq.size() == 0) check(1'b0, "R3", "unexpected tx word", fifo_tx_data, '0);
            else begin
                logic [63:0] e;
                e = tq.pop_front();
                check(fifo_tx_data === e, "R3", "tx word", fifo_tx_data, e);
            end
        end

        // stalls keep requests waiting (R13): address is compared when acked
        mem_ack = mem_req && ((cyc % 4) != 2);
        mem_err = 1'b0;
        if (mem_ack) begin
            mem_rdata = pat(mem_addr);
            if (err_arm) begin
                mem_err = 1'b1;
                err_arm = 0;
            end else if (mq.size() == 0) begin
                check(1'b0, "R13", "unexpected memory request", mem_addr, '0);
            end else begin
                mitem_t it;
                it = mq.pop_front();
                check(mem_addr === it.a, "R6", "beat address", mem_addr, it.a);
                check(mem_wr === it.wr, it.wr ? "R4" : "R3", "direction", 64'(mem_wr), 64'(it.wr));
                check(mem_size === it.sz, "R5", "beat size", 64'(mem_size), 64'(it.sz));
                if (it.wr) check(mem_wdata === it.d, "R4", "write data", mem_wdata, it.d);
            end
        end
    end

    task automatic reg_wr(input logic [2:0] i, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = i; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] i, output logic [31:0] v);
        @(negedge clk);
        reg_idx = i;
        #1;
        v = reg_rdata;
    endtask

    task automatic start_xfer(input logic [1:0] dirf, input logic [1:0] w,
                              input logic inc, input logic [63:0] a,
                              input logic [15:0] nb, input bit push, output int d0);
        int beats;
        reg_wr(I_MODE, (32'(dirf) << 16) | (32'(w) << 4) | 32'(inc));
        reg_wr(I_ALO, a[31:0]);
        reg_wr(I_AHI, a[63:32]);
        xfer_bytes = nb;
        beats = int'(nb >> w);
        if (push) begin
            for (int i = 0; i < beats; i++) begin
                logic [63:0] ai;
                ai = inc ? a + (64'(i) << w) : a;
                if (dirf == 2'd1) mq.push_back('{a: ai, d: rxval(rx_idx + i), wr: 1'b1, sz: w});
                else begin
                    mq.push_back('{a: ai, d: 64'd0, wr: 1'b0, sz: w});
                    tq.push_back(pat(ai));
                end
            end
        end
        d0 = done_cnt;
        reg_wr(I_CTRL, 32'h1);
    endtask

    task automatic finish_xfer(input int d0, input string req);
        logic [31:0] v;
        for (int k = 0; k < 3000 && done_cnt == d0; k++) @(negedge clk);
        @(negedge clk);
        check(done_cnt == d0 + 1, "R8", {req, " single done pulse"}, 64'(done_cnt), 64'(d0 + 1));
        check(mq.size() == 0 && tq.size() == 0, req, "all beats seen",
              64'(mq.size() + tq.size()), 64'd0);
        reg_rd(I_CTRL, v);
        check(v == 32'h0, "R2", "go bit cleared after end", 64'(v), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_rd(I_MODE, v);  check(v == 0, "R1", "MODE reset", 64'(v), 0);
        reg_rd(I_CTRL, v);  check(v == 0, "R1", "CTRL reset", 64'(v), 0);
        reg_rd(I_CHRST, v); check(v == 32'h300, "R1", "CHRST reset", 64'(v), 64'h300);
        reg_rd(I_STAT, v);  check(v == 0, "R1", "STATUS reset", 64'(v), 0);
        reg_rd(I_AHI, v);   check(v == 0, "R1", "ADDR_HI reset", 64'(v), 0);
        check(!mem_req && !fifo_tx_valid && !fifo_rx_ready, "R1", "idle ports", 64'(mem_req), 0);

        // R3 R5 R6 R7: 64-bit incrementing read above 4 GiB
        start_xfer(2'd0, 2'd3, 1'b1, 64'h1_0000_0040, 16'd32, 1, d0);
        reg_rd(I_CTRL, v); check(v == 1, "R2", "go bit reads busy", 64'(v), 1);
        finish_xfer(d0, "R7");

        // R4: 32-bit incrementing write
        start_xfer(2'd1, 2'd2, 1'b1, 64'h2000, 16'd12, 1, d0);
        finish_xfer(d0, "R4");

        // R3: direction code 2 behaves as memory-to-device, byte beats, fixed
        start_xfer(2'd2, 2'd0, 1'b0, 64'h3013, 16'd3, 1, d0);
        finish_xfer(d0, "R6");

        // R4 R6: 16-bit fixed-address write
        start_xfer(2'd1, 2'd1, 1'b0, 64'h4002, 16'd8, 1, d0);
        finish_xfer(d0, "R5");

        // R8: zero beats (2 bytes at 4-byte beats) -> immediate pulse
        start_xfer(2'd0, 2'd2, 1'b1, 64'h5000, 16'd2, 1, d0);
        #1;
        check(xfer_done === 1'b1, "R8", "zero-length pulse", 64'(xfer_done), 1);
        check(mem_req === 1'b0, "R8", "zero-length no request", 64'(mem_req), 0);
        @(negedge clk); #1;
        check(xfer_done === 1'b0, "R8", "pulse is one cycle", 64'(xfer_done), 0);

        // R9: writes while busy are ignored
        start_xfer(2'd0, 2'd3, 1'b1, 64'h6000, 16'd64, 1, d0);
        reg_wr(I_MODE, 32'h0001_0021);
        reg_wr(I_ALO, 32'hDEAD_0000);
        finish_xfer(d0, "R9");
        reg_rd(I_MODE, v); check(v == 32'h31, "R9", "MODE kept", 64'(v), 64'h31);
        reg_rd(I_ALO, v);  check(v == 32'h6000, "R9", "ADDR_LO kept", 64'(v), 64'h6000);

        // R10: hold channel 0 mid-transfer
        start_xfer(2'd0, 2'd3, 1'b1, 64'h8000, 16'd128, 1, d0);
        repeat (6) @(negedge clk);
        reg_wr(I_CHRST, 32'h200);
        reg_rd(I_CTRL, v);
        check(v == 0, "R10", "abort stops transfer", 64'(v), 0);
        check(!mem_req && !fifo_tx_valid, "R10", "abort drops requests", 64'(mem_req), 0);
        repeat (3) @(negedge clk);
        check(done_cnt == d0, "R10", "no done after abort", 64'(done_cnt), 64'(d0));
        mq.delete(); tq.delete();
        start_xfer(2'd0, 2'd3, 1'b1, 64'h8800, 16'd8, 0, d0);
        repeat (3) @(negedge clk);
        reg_rd(I_CTRL, v);
        check(v == 0, "R10", "start refused while held", 64'(v), 0);
        check(done_cnt == d0, "R10", "no done while held", 64'(done_cnt), 64'(d0));
        reg_wr(I_CHRST, 32'h300);
        start_xfer(2'd0, 2'd3, 1'b1, 64'h8800, 16'd16, 1, d0);
        finish_xfer(d0, "R10");

        // R11: memory error on a write beat, sticky until channel 1 is held
        err_arm = 1;
        start_xfer(2'd1, 2'd2, 1'b1, 64'h9000, 16'd8, 0, d0);
        repeat (12) @(negedge clk);
        reg_rd(I_STAT, v); check(v == 2, "R11", "error flag ch1", 64'(v), 2);
        check(done_cnt == d0, "R11", "no done on error", 64'(done_cnt), 64'(d0));
        reg_rd(I_CTRL, v); check(v == 0, "R11", "stopped on error", 64'(v), 0);
        start_xfer(2'd0, 2'd3, 1'b1, 64'hA000, 16'd8, 1, d0);
        finish_xfer(d0, "R11");
        reg_rd(I_STAT, v); check(v == 2, "R11", "error flag sticky", 64'(v), 2);
        reg_wr(I_CHRST, 32'h100);
        reg_rd(I_STAT, v); check(v == 0, "R11", "error cleared by hold", 64'(v), 0);
        reg_wr(I_CHRST, 32'h300);

        // R12: misaligned 8-byte start is refused
        start_xfer(2'd0, 2'd3, 1'b1, 64'hB004, 16'd16, 0, d0);
        repeat (4) @(negedge clk);
        reg_rd(I_STAT, v); check(v == 1, "R12", "misalign error ch0", 64'(v), 1);
        reg_rd(I_CTRL, v); check(v == 0, "R12", "misalign not started", 64'(v), 0);
        check(done_cnt == d0, "R12", "misalign no done", 64'(done_cnt), 64'(d0));
        reg_wr(I_CHRST, 32'h200);
        reg_wr(I_CHRST, 32'h300);
        reg_rd(I_STAT, v); check(v == 0, "R12", "misalign flag cleared", 64'(v), 0);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule